// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source side of a two-level interrupt controller. It keeps a table of interrupt sources. For each source it holds a destination server, a priority, a saved priority and a set of status flags. Each source is fixed by a parameter as either edge-triggered (message style) or level-triggered. Source events arrive on one input line per source. When a source is due for service it is offered to the presentation layer through a valid/ready channel, which carries the global source number, the server and the priority.

The presentation layer talks back to the block with three kinds of pulse:
- A reject refuses an offered source.
- A resend request starts a sweep over the whole table, one source per clock. The sweep pauses while an offer is stalled.
- An end-of-interrupt notice retires a level source that was in service.

A configuration port accepts four commands: set, get, disable and enable. Each command returns a status code one cycle later. Disable and enable work by exchanging the priority with the mask value 0xFF, using the saved priority field to hold the old value.

The number of sources, the first global source number and the number of servers are parameters. The default configuration has eight sources numbered 16 to 23, of which 20 to 23 are level sources, and four servers.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset every status flag is clear, every priority and saved priority reads 0xFF, the server reads 0, `out_valid` is low and `rsp_valid` is low.
- R2: A rising edge on the line of an edge source whose priority is not 0xFF queues an offer carrying number BASE_NUM+index, its server and its priority. If the priority is 0xFF, the edge is remembered as masked-pending and no offer is made.
- R3: For a level source, a change on its line copies the new line value into its asserted flag and runs the level check. The level check queues an offer only when the source is unmasked, asserted and not yet sent, and it sets the sent flag when it does. A line that stays high therefore produces only one offer.
- R4: A reject pulse naming a source in range sets that source's rejected flag and clears its sent flag. A reject with an out-of-range number changes nothing.
- R5: A resend pulse starts a sweep that visits sources in index order, one per cycle. The sweep does not advance while `out_valid` is high and `out_ready` is low. When it visits a level source it runs the level check. When it visits an edge source that is marked rejected, it clears that mark and queues an offer if the source is unmasked.
- R6: An end-of-interrupt pulse clears the sent flag of a level source, so a later sweep offers the source again if its line is still high. On an edge source it has no effect.
- R7: Every accepted configuration write runs a hook on the source it names:
  - An edge source that is masked-pending and now unmasked clears the flag and queues an offer.
  - A level source runs the level check.
  - A write that masks a source with a queued offer withdraws the offer. An edge source becomes masked-pending; a level source has its sent flag cleared.
- R8: Set (`cmd_op` = 0) is refused with status 0xFD (-3) in any of these cases: the number is outside BASE_NUM to BASE_NUM+NUM_SRC-1, the server is not below NUM_SERVERS, or the priority is above 0xFF. Otherwise it stores the server and writes the priority into both the priority and the saved priority, and returns status 0.
- R9: Disable (`cmd_op` = 2) moves the current priority into the saved priority field and sets the priority to 0xFF. Enable (`cmd_op` = 3) copies the saved priority into the priority. Disabling twice leaves 0xFF in both fields.
- R10: Get (`cmd_op` = 1) returns status 0, the server and the current priority. For a number out of range, every command returns status 0xFD with zero server and priority. Only a valid get returns non-zero server or priority fields.
- R11: At most one offer is presented at a time; the lowest queued index wins. An offer is held while `out_ready` is low and is retired in the cycle in which both `out_valid` and `out_ready` are high. No offer ever carries priority 0xFF.
- R12: `rsp_valid` is high for exactly one cycle, in the cycle after each cycle in which `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | One event line per source |
| out_valid | output | 1 | An offer is presented |
| out_ready | input | 1 | Presentation layer takes the offer |
| out_num | output | NUM_W | Global number of the offered source |
| out_server | output | 8 | Destination server of the offer |
| out_prio | output | 8 | Priority of the offer |
| rej_valid | input | 1 | Reject pulse |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | NUM_W | Global number of the retired source |
| resend_req | input | 1 | Start a resend sweep |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_op | input | 2 | 0 set, 1 get, 2 disable, 3 enable |
| cmd_num | input | NUM_W | Global source number of the command |
| cmd_server | input | 8 | Server for set |
| cmd_prio | input | 16 | Priority for set |
| rsp_valid | output | 1 | Command response strobe |
| rsp_status | output | 8 | 0x00 success, 0xFD refused |
| rsp_server | output | 8 | Server returned by get |
| rsp_prio | output | 8 | Priority returned by get |

## Verification
The assertions check the following on every cycle:
- No offer ever shows the mask priority.
- An edge source is masked-pending only while it is masked, and it never holds a sent mark.
- A response follows each command by exactly one cycle and carries one of the two status codes.
- A resend sweep holds its place while an offer is stalled and otherwise steps one index at a time.

The sequences that span many cycles can only be shown by the bench's scenarios. These are reject followed by resend, end-of-interrupt on a level line that is still high, masked-pending released by enable, and the priority swap of disable and enable. The bench runs them against a behavioural model that it compares on every clock.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int PRIO_W = 8;
    localparam int SRV_W  = 8;

    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;
    localparam logic [7:0]        ST_OK    = 8'h00;
    localparam logic [7:0]        ST_BAD   = 8'hFD;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_GET = 2'd1,
        OP_OFF = 2'd2,
        OP_ON  = 2'd3
    } cmd_op_e;

    typedef struct packed {
        logic [SRV_W-1:0]  server;
        logic [PRIO_W-1:0] prio;
        logic [PRIO_W-1:0] saved;
    } src_cfg_t;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } src_flags_t;

    localparam src_cfg_t CFG_RESET = '{server: '0, prio: PRIO_OFF, saved: PRIO_OFF};

    function automatic logic is_masked(input logic [PRIO_W-1:0] p);
        return p == PRIO_OFF;
    endfunction

endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
    import isc_pkg::*;
#(
    parameter bit LEVEL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    input  logic     acc_hit,
    input  logic     rej_hit,
    input  logic     eoi_hit,
    input  logic     scan_hit,
    input  logic     wr_hit,
    input  src_cfg_t wr_cfg,
    output src_cfg_t cfg,
    output logic     want
);

    src_flags_t flags, n_flags;
    src_cfg_t   n_cfg;
    logic       n_want;
    logic       lvl_chk;

    always_comb begin
        n_cfg   = cfg;
        n_flags = flags;
        n_want  = want;
        lvl_chk = 1'b0;

        // offer taken by the presentation layer
        if (acc_hit) n_want = 1'b0;

        // reject from the presentation layer (R4)
        if (rej_hit) begin
            n_flags.rejected = 1'b1;
            n_flags.sent     = 1'b0;
        end

        // end of interrupt (R6): only level sources react
        if (LEVEL && eoi_hit) n_flags.sent = 1'b0;

        // line handling (R2, R3)
        if (LEVEL) begin
            if (line_in != flags.asserted) begin
                n_flags.asserted = line_in;
                lvl_chk          = 1'b1;
            end
        end else begin
            if (line_in && !flags.asserted) begin
                if (is_masked(n_cfg.prio)) n_flags.mpend = 1'b1;
                else                       n_want        = 1'b1;
            end
            n_flags.asserted = line_in;
        end

        // configuration write hooks (R7)
        if (wr_hit) begin
            n_cfg = wr_cfg;
            if (LEVEL) lvl_chk = 1'b1;
            if (is_masked(wr_cfg.prio)) begin
                if (n_want) begin
                    n_want = 1'b0;
                    if (LEVEL) n_flags.sent  = 1'b0;
                    else       n_flags.mpend = 1'b1;
                end
            end else if (!LEVEL && n_flags.mpend) begin
                n_flags.mpend = 1'b0;
                n_want        = 1'b1;
            end
        end

        // resend sweep visit (R5)
        if (scan_hit) begin
            if (LEVEL) begin
                lvl_chk = 1'b1;
            end else if (n_flags.rejected) begin
                n_flags.rejected = 1'b0;
                if (!is_masked(n_cfg.prio)) n_want = 1'b1;
            end
        end

        // level check (R3)
        if (LEVEL && lvl_chk && !is_masked(n_cfg.prio)
            && n_flags.asserted && !n_flags.sent) begin
            n_flags.sent = 1'b1;
            n_want       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            flags <= '0;
            want  <= 1'b0;
        end else begin
            cfg   <= n_cfg;
            flags <= n_flags;
            want  <= n_want;
        end
    end

    // R11: a queued offer always belongs to an unmasked source
    a_r11_want_unmasked: assert property (@(posedge clk) disable iff (rst)
        want |-> !is_masked(cfg.prio));

    if (!LEVEL) begin : g_edge_chk
        // R2: masked-pending only survives while the source stays masked
        a_r2_mpend_masked: assert property (@(posedge clk) disable iff (rst)
            flags.mpend |-> is_masked(cfg.prio));
        // R6: edge sources never carry a sent mark
        a_r6_edge_never_sent: assert property (@(posedge clk) disable iff (rst)
            !flags.sent);
    end

endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] want_vec,
    output logic               any,
    output logic [IDX_W-1:0]   sel
);

    // lowest index wins (R11)
    always_comb begin
        sel = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (want_vec[i]) sel = IDX_W'(i);
        end
    end

    assign any = |want_vec;

endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stall,
    output logic             scan_hit,
    output logic [IDX_W-1:0] scan_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    logic             busy;
    logic [IDX_W-1:0] idx_q;

    assign scan_hit = busy && !stall;
    assign scan_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (scan_hit) begin
            if (idx_q == LAST) busy  <= 1'b0;
            else               idx_q <= idx_q + 1'b1;
        end
    end

    // R5: a stalled offer freezes the sweep in place
    a_r5_scan_waits: assert property (@(posedge clk) disable iff (rst)
        (busy && stall && !start) |=> (busy && $stable(idx_q)));

    // R5: an unstalled sweep steps one index per cycle
    a_r5_scan_order: assert property (@(posedge clk) disable iff (rst)
        (scan_hit && !start && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/isc_cmd_port.sv
module isc_cmd_port
    import isc_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int BASE_NUM    = 16,
    parameter int NUM_SERVERS = 4,
    parameter int NUM_W       = 16,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [NUM_W-1:0] cmd_num,
    input  logic [7:0]       cmd_server,
    input  logic [15:0]      cmd_prio,
    input  src_cfg_t         cur_cfg,
    output logic [IDX_W-1:0] look_idx,
    output logic             wr_en,
    output src_cfg_t         wr_cfg,
    output logic             rsp_valid,
    output logic [7:0]       rsp_status,
    output logic [7:0]       rsp_server,
    output logic [7:0]       rsp_prio
);

    cmd_op_e    op;
    logic       in_rng;
    logic       srv_bad;
    logic       pr_bad;
    logic [7:0] st_d;
    logic [7:0] srv_d;
    logic [7:0] pr_d;

    assign op       = cmd_op_e'(cmd_op);
    assign in_rng   = (int'(cmd_num) >= BASE_NUM) && (int'(cmd_num) < BASE_NUM + NUM_SRC);
    assign look_idx = IDX_W'(int'(cmd_num) - BASE_NUM);
    assign srv_bad  = int'(cmd_server) >= NUM_SERVERS;
    assign pr_bad   = cmd_prio[15:8] != 8'h00;

    always_comb begin
        wr_en  = 1'b0;
        wr_cfg = cur_cfg;
        st_d   = ST_OK;
        srv_d  = '0;
        pr_d   = '0;
        if (cmd_valid) begin
            if (!in_rng) begin
                st_d = ST_BAD;
            end else begin
                case (op)
                    OP_SET: begin
                        if (srv_bad || pr_bad) begin
                            st_d = ST_BAD;
                        end else begin
                            wr_en         = 1'b1;
                            wr_cfg.server = cmd_server;
                            wr_cfg.prio   = cmd_prio[7:0];
                            wr_cfg.saved  = cmd_prio[7:0];
                        end
                    end
                    OP_GET: begin
                        srv_d = cur_cfg.server;
                        pr_d  = cur_cfg.prio;
                    end
                    OP_OFF: begin
                        wr_en        = 1'b1;
                        wr_cfg.prio  = PRIO_OFF;
                        wr_cfg.saved = cur_cfg.prio;
                    end
                    OP_ON: begin
                        wr_en       = 1'b1;
                        wr_cfg.prio = cur_cfg.saved;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_server <= '0;
            rsp_prio   <= '0;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_status <= st_d;
            rsp_server <= srv_d;
            rsp_prio   <= pr_d;
        end
    end

    // R12: exactly one response per command, one cycle later
    a_r12_rsp_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);
    a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    // R8: only the two status codes ever appear
    a_r8_status_codes: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status == ST_OK || rsp_status == ST_BAD));

endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
    import isc_pkg::*;
#(
    parameter int                 NUM_SRC     = 8,
    parameter int                 BASE_NUM    = 16,
    parameter int                 NUM_SERVERS = 4,
    parameter int                 NUM_W       = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK  = 8'hF0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_line,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [NUM_W-1:0]   out_num,
    output logic [7:0]         out_server,
    output logic [7:0]         out_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [NUM_W-1:0]   cmd_num,
    input  logic [7:0]         cmd_server,
    input  logic [15:0]        cmd_prio,
    output logic               rsp_valid,
    output logic [7:0]         rsp_status,
    output logic [7:0]         rsp_server,
    output logic [7:0]         rsp_prio
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    src_cfg_t           slot_cfg [NUM_SRC];
    logic [NUM_SRC-1:0] want_vec;
    logic               arb_any;
    logic [IDX_W-1:0]   arb_sel;
    logic               take;
    logic               stall;
    logic               scan_hit;
    logic [IDX_W-1:0]   scan_idx;
    logic [IDX_W-1:0]   look_idx;
    src_cfg_t           cur_cfg;
    logic               wr_en;
    src_cfg_t           wr_cfg;

    assign take  = arb_any && out_ready;
    assign stall = arb_any && !out_ready;

    isc_offer_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
        .want_vec (want_vec),
        .any      (arb_any),
        .sel      (arb_sel)
    );

    isc_resend_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) scan_i (
        .clk      (clk),
        .rst      (rst),
        .start    (resend_req),
        .stall    (stall),
        .scan_hit (scan_hit),
        .scan_idx (scan_idx)
    );

    always_comb begin
        cur_cfg = CFG_RESET;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (look_idx == IDX_W'(i)) cur_cfg = slot_cfg[i];
        end
    end

    isc_cmd_port #(
        .NUM_SRC(NUM_SRC), .BASE_NUM(BASE_NUM), .NUM_SERVERS(NUM_SERVERS),
        .NUM_W(NUM_W), .IDX_W(IDX_W)
    ) cmd_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_num    (cmd_num),
        .cmd_server (cmd_server),
        .cmd_prio   (cmd_prio),
        .cur_cfg    (cur_cfg),
        .look_idx   (look_idx),
        .wr_en      (wr_en),
        .wr_cfg     (wr_cfg),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_server (rsp_server),
        .rsp_prio   (rsp_prio)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        isc_src_slot #(.LEVEL(LEVEL_MASK[i])) slot_i (
            .clk      (clk),
            .rst      (rst),
            .line_in  (src_line[i]),
            .acc_hit  (take && arb_sel == IDX_W'(i)),
            .rej_hit  (rej_valid && int'(rej_num) == BASE_NUM + i),
            .eoi_hit  (eoi_valid && int'(eoi_num) == BASE_NUM + i),
            .scan_hit (scan_hit && scan_idx == IDX_W'(i)),
            .wr_hit   (wr_en && look_idx == IDX_W'(i)),
            .wr_cfg   (wr_cfg),
            .cfg      (slot_cfg[i]),
            .want     (want_vec[i])
        );
    end

    assign out_valid  = arb_any;
    assign out_num    = NUM_W'(BASE_NUM + int'(arb_sel));
    assign out_server = slot_cfg[arb_sel].server;
    assign out_prio   = slot_cfg[arb_sel].prio;

    // R11: the mask value never reaches the presentation layer
    a_r11_no_masked_offer: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_prio != PRIO_OFF);

endmodule

// File: tb/isc_source_ctrl_tb_top.sv
module isc_source_ctrl_tb_top;

    localparam int N    = 8;
    localparam int BASE = 16;
    localparam int NSRV = 4;
    localparam logic [N-1:0] LVL = 8'hF0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line = '0;
    logic         ready = 1'b1;
    logic         rej_v = 1'b0, eoi_v = 1'b0, rs_req = 1'b0, c_v = 1'b0;
    logic [15:0]  rej_n = '0, eoi_n = '0, c_num = '0;
    logic [1:0]   c_op = '0;
    logic [7:0]   c_srv = '0;
    logic [15:0]  c_pr = '0;

    logic        out_valid, rsp_valid;
    logic [15:0] out_num;
    logic [7:0]  out_server, out_prio, rsp_status, rsp_server, rsp_prio;

    always #4 clk = ~clk;

    isc_source_ctrl dut_i (
        .clk(clk), .rst(rst), .src_line(line),
        .out_valid(out_valid), .out_ready(ready), .out_num(out_num),
        .out_server(out_server), .out_prio(out_prio),
        .rej_valid(rej_v), .rej_num(rej_n), .eoi_valid(eoi_v), .eoi_num(eoi_n),
        .resend_req(rs_req), .cmd_valid(c_v), .cmd_op(c_op), .cmd_num(c_num),
        .cmd_server(c_srv), .cmd_prio(c_pr),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_server(rsp_server), .rsp_prio(rsp_prio)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;

    // behavioural reference state
    int m_prio[N], m_saved[N], m_srv[N];
    bit m_ast[N], m_snt[N], m_rej[N], m_mp[N], m_want[N];
    bit m_scan;
    int m_si;
    bit m_rv;
    int m_rst, m_rsrv, m_rpr;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick();
        for (int i = 0; i < N; i++) if (m_want[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 255; m_saved[i] = 255; m_srv[i] = 0;
            m_ast[i] = 0; m_snt[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_want[i] = 0;
        end
        m_scan = 0; m_si = 0; m_rv = 0; m_rst = 0; m_rsrv = 0; m_rpr = 0;
    endtask

    task automatic check_all();
        int s;
        s = pick();
        chk("R11 out_valid", int'(out_valid), int'(s >= 0));
        if (s >= 0) begin
            chk("R2 out_num", int'(out_num), BASE + s);
            chk("R2 out_server", int'(out_server), m_srv[s]);
            chk("R11 out_prio", int'(out_prio), m_prio[s]);
        end
        chk("R12 rsp_valid", int'(rsp_valid), int'(m_rv));
        if (m_rv) begin
            chk("R8 rsp_status", int'(rsp_status), m_rst);
            chk("R10 rsp_server", int'(rsp_server), m_rsrv);
            chk("R10 rsp_prio", int'(rsp_prio), m_rpr);
        end
    endtask

    task automatic model_write(input int k, input int np, input int ns, input int nsv,
                               inout bit lchk[N]);
        m_prio[k] = np; m_saved[k] = ns; m_srv[k] = nsv;
        if (LVL[k]) lchk[k] = 1;
        if (np == 255) begin
            if (m_want[k]) begin
                m_want[k] = 0;
                if (LVL[k]) m_snt[k] = 0; else m_mp[k] = 1;
            end
        end else if (!LVL[k] && m_mp[k]) begin
            m_mp[k] = 0; m_want[k] = 1;
        end
    endtask

    task automatic model_step();
        int s, k, np, ns, nsv;
        bit stall, hit, ok, wr;
        bit lchk[N];
        s = pick();
        stall = (s >= 0) && !ready;
        hit = m_scan && !stall;
        if (s >= 0 && ready) m_want[s] = 0;
        for (int i = 0; i < N; i++) begin
            lchk[i] = 0;
            if (rej_v && int'(rej_n) == BASE + i) begin m_rej[i] = 1; m_snt[i] = 0; end
            if (eoi_v && int'(eoi_n) == BASE + i && LVL[i]) m_snt[i] = 0;
            if (LVL[i]) begin
                if (line[i] != m_ast[i]) begin m_ast[i] = line[i]; lchk[i] = 1; end
            end else begin
                if (line[i] && !m_ast[i]) begin
                    if (m_prio[i] == 255) m_mp[i] = 1; else m_want[i] = 1;
                end
                m_ast[i] = line[i];
            end
        end
        m_rv = c_v; m_rst = 0; m_rsrv = 0; m_rpr = 0;
        if (c_v) begin
            k = int'(c_num) - BASE;
            ok = int'(c_num) >= BASE && int'(c_num) < BASE + N;
            wr = 0; np = 0; ns = 0; nsv = 0;
            if (!ok) m_rst = 'hFD;
            else begin
                case (c_op)
                    2'd0: if (int'(c_srv) >= NSRV || int'(c_pr) > 255) m_rst = 'hFD;
                          else begin wr = 1; np = int'(c_pr); ns = int'(c_pr); nsv = int'(c_srv); end
                    2'd1: begin m_rsrv = m_srv[k]; m_rpr = m_prio[k]; end
                    2'd2: begin wr = 1; np = 255; ns = m_prio[k]; nsv = m_srv[k]; end
                    default: begin wr = 1; np = m_saved[k]; ns = m_saved[k]; nsv = m_srv[k]; end
                endcase
            end
            if (wr) model_write(k, np, ns, nsv, lchk);
        end
        if (hit) begin
            k = m_si;
            if (LVL[k]) lchk[k] = 1;
            else if (m_rej[k]) begin
                m_rej[k] = 0;
                if (m_prio[k] != 255) m_want[k] = 1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (LVL[i] && lchk[i] && m_prio[i] != 255 && m_ast[i] && !m_snt[i]) begin
                m_snt[i] = 1; m_want[i] = 1;
            end
        end
        if (rs_req) begin m_scan = 1; m_si = 0; end
        else if (hit) begin
            if (m_si == N - 1) m_scan = 0; else m_si++;
        end
    endtask

    task automatic tick();
        check_all();
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cmd(input int op, input int num, input int srv, input int pr);
        c_v = 1; c_op = 2'(op); c_num = 16'(num); c_srv = 8'(srv); c_pr = 16'(pr);
        tick();
        c_v = 0;
    endtask

    task automatic pulse(input int i);
        line[i] = 1'b1; tick(); line[i] = 1'b0; tick();
    endtask

    task automatic rej(input int n);
        rej_v = 1; rej_n = 16'(n); tick(); rej_v = 0;
    endtask

    task automatic eoi(input int n);
        eoi_v = 1; eoi_n = 16'(n); tick(); eoi_v = 0;
    endtask

    task automatic resend();
        rs_req = 1; tick(); rs_req = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1-all: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag = "R1";
        idle(2);
        cmd(1, 16, 0, 0);
        chk("R1 get prio after reset", int'(rsp_prio), 255);
        chk("R1 get server after reset", int'(rsp_server), 0);
        idle(1);

        // R8 / R10: set and range checks
        tag = "R8";
        cmd(0, 16, 2, 5);
        chk("R8 set status", int'(rsp_status), 'h00);
        cmd(0, 15, 0, 1);
        chk("R8 below range", int'(rsp_status), 'hFD);
        cmd(0, 24, 0, 1);
        chk("R8 above range", int'(rsp_status), 'hFD);
        cmd(0, 17, 4, 3);
        chk("R8 server range", int'(rsp_status), 'hFD);
        cmd(0, 17, 1, 'h100);
        chk("R8 prio range", int'(rsp_status), 'hFD);
        tag = "R10";
        cmd(1, 16, 0, 0);
        chk("R10 get server", int'(rsp_server), 2);
        chk("R10 get prio", int'(rsp_prio), 5);
        cmd(1, 40, 0, 0);
        chk("R10 bad get status", int'(rsp_status), 'hFD);

        // R2 / R11: edge offer held while stalled
        tag = "R2";
        ready = 0;
        pulse(0);
        chk("R2 offer num", int'(out_num), 16);
        idle(3);
        ready = 1;
        idle(2);
        // masked edge then unmask (R7)
        pulse(1);
        idle(2);
        tag = "R7";
        cmd(0, 17, 3, 9);
        chk("R7 released offer", int'(out_valid), 1);
        idle(2);

        // R11: lowest index first
        tag = "R11";
        cmd(0, 18, 1, 4);
        ready = 0;
        line[2:0] = 3'b111; tick(); line[2:0] = 3'b000; tick();
        chk("R11 lowest first", int'(out_num), 16);
        ready = 1;
        idle(4);

        // R4 / R5: reject, masked reject, stalled sweep
        tag = "R4";
        rej(16);
        rej(17);
        rej(99);
        cmd(2, 17, 0, 0);
        tag = "R5";
        ready = 0;
        resend();
        idle(6);
        ready = 1;
        idle(12);

        // R3 / R6: level source life cycle
        tag = "R3";
        cmd(0, 20, 1, 7);
        line[4] = 1;
        idle(4);
        rej(20);
        resend();
        idle(10);
        tag = "R6";
        eoi(20);
        resend();
        idle(10);
        line[4] = 0;
        tick();
        eoi(20);
        resend();
        idle(10);
        eoi(16);
        idle(2);
        tag = "R7";
        line[5] = 1;
        idle(2);
        cmd(0, 21, 0, 2);
        idle(3);

        // R9: disable / enable swap
        tag = "R9";
        cmd(2, 16, 0, 0);
        cmd(1, 16, 0, 0);
        chk("R9 disabled prio", int'(rsp_prio), 255);
        cmd(3, 16, 0, 0);
        cmd(1, 16, 0, 0);
        chk("R9 enabled prio", int'(rsp_prio), 5);
        cmd(2, 16, 0, 0);
        cmd(2, 16, 0, 0);
        cmd(3, 16, 0, 0);
        cmd(1, 16, 0, 0);
        chk("R9 double disable prio", int'(rsp_prio), 255);

        // R7: masking withdraws queued offers
        tag = "R7";
        ready = 0;
        pulse(2);
        cmd(2, 18, 0, 0);
        idle(2);
        cmd(3, 18, 0, 0);
        idle(2);
        ready = 1;
        idle(2);
        cmd(0, 22, 1, 1);
        ready = 0;
        line[6] = 1;
        idle(2);
        cmd(2, 22, 0, 0);
        idle(2);
        cmd(3, 22, 0, 0);
        idle(2);
        ready = 1;
        tag = "R12";
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule